// File: doc/BRIEF.md
# Seat Belt Reminder Controller

This controller watches an occupancy sensor and a belt-latch sensor for one seat and sounds an alarm when an occupant stays unbelted for too long. The length of that grace period is measured outside the block: the controller raises a run request to an external interval timer while it waits, and watches that timer's completion flag. When the flag arrives while the occupant is still seated and unbelted, the chime output turns on. It stays on until the belt is latched or the seat is emptied.

The controller has four states: seat empty, waiting for the belt, alarm, and secured (seated and belted). Both outputs are decoded from the state register alone. Each output therefore changes in the cycle after the input change that causes it. The run request is high only while the controller waits. When it drops, the external timer is cleared, and when it rises again, the timer starts a fresh interval. Sensor debouncing, interval counting and tone generation are done elsewhere.

Top module: `belt_reminder_ctrl`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, interval_run_o and chime_o are both 0. Asserting rst_n clears both outputs at once, without waiting for a clock edge.
- R2: If the seat becomes occupied (seat_occupied_i=1) with the belt open (belt_latched_i=0), interval_run_o is 1 after the next rising edge and chime_o stays 0.
- R3: While waiting, an interval_done_i of 1 with the seat still occupied and the belt open sets chime_o to 1 and interval_run_o to 0 after the next edge. chime_o never rises without interval_run_o and interval_done_i having both been 1 in the previous cycle.
- R4: When the belt is latched while the seat is occupied, both outputs are 0 after the next edge. This holds from any state.
- R5: When seat_occupied_i is 0 at an edge, both outputs are 0 after that edge, whatever the other inputs are.
- R6: From the secured state, opening the belt while still seated sets interval_run_o back to 1 after the next edge. This restarts the interval.
- R7: interval_done_i has no effect unless the controller is waiting. With the seat empty, or with the occupant belted, chime_o stays 0 when interval_done_i is 1.
- R8: Sitting down with the belt already latched leaves interval_run_o at 0.
- R9: If the belt latches in the same cycle that interval_done_i is 1 while waiting, the belt wins: chime_o stays 0.
- R10: Once chime_o is 1, it stays 1 while the seat is occupied and the belt is open, even after interval_done_i falls.
- R11: interval_run_o and chime_o are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| seat_occupied_i | input | 1 | 1 = person seated, 0 = seat empty |
| belt_latched_i | input | 1 | 1 = belt fastened, 0 = open |
| interval_done_i | input | 1 | 1 = external interval has elapsed |
| interval_run_o | output | 1 | Run request to the external interval timer; held high while waiting |
| chime_o | output | 1 | Alarm buzzer drive |

## Verification
The assertions assume the sensor inputs are already synchronous to clk and free of bounce. They also assume interval_done_i reports the elapsed interval for the current run request. They do not check how the external timer counts; they only check how the controller reacts to the flag. The directed stimulus changes inputs only on the falling edge. In most scenarios it raises interval_done_i only while the run request is high. The scenarios that check that the flag is ignored (R7) deliberately raise it while the controller is not waiting.

// File: rtl/belt_rmd_pkg.sv
package belt_rmd_pkg;
  typedef enum logic [1:0] {
    ST_EMPTY   = 2'd0,
    ST_WAIT    = 2'd1,
    ST_ALARM   = 2'd2,
    ST_SECURED = 2'd3
  } seat_state_e;
endpackage

// File: rtl/belt_next_state.sv
module belt_next_state
  import belt_rmd_pkg::*;
(
  input  seat_state_e cur_st,
  input  logic        occupied,
  input  logic        latched,
  input  logic        done,
  output seat_state_e nxt_st
);
  // Priority order: an empty seat first, then a latched belt, then timer expiry.
  always_comb begin
    nxt_st = cur_st;
    if (!occupied) begin
      nxt_st = ST_EMPTY;
    end else if (latched) begin
      nxt_st = ST_SECURED;
    end else begin
      unique case (cur_st)
        ST_EMPTY:   nxt_st = ST_WAIT;
        ST_SECURED: nxt_st = ST_WAIT;
        ST_WAIT:    nxt_st = done ? ST_ALARM : ST_WAIT;
        ST_ALARM:   nxt_st = ST_ALARM;
        default:    nxt_st = ST_EMPTY;
      endcase
    end
  end
endmodule

// File: rtl/belt_out_decode.sv
module belt_out_decode
  import belt_rmd_pkg::*;
(
  input  seat_state_e cur_st,
  output logic        run_req,
  output logic        chime
);
  always_comb begin
    run_req = (cur_st == ST_WAIT);
    chime   = (cur_st == ST_ALARM);
  end
endmodule

// File: rtl/belt_reminder_ctrl.sv
module belt_reminder_ctrl
  import belt_rmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic seat_occupied_i,
  input  logic belt_latched_i,
  input  logic interval_done_i,
  output logic interval_run_o,
  output logic chime_o
);
  seat_state_e state_q;
  seat_state_e state_d;
  logic        st_en;

  // The state register is updated on every cycle.
  assign st_en = 1'b1;

  belt_next_state u_next (
    .cur_st   (state_q),
    .occupied (seat_occupied_i),
    .latched  (belt_latched_i),
    .done     (interval_done_i),
    .nxt_st   (state_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_EMPTY;
    end else if (st_en) begin
      state_q <= state_d;
    end
  end

  belt_out_decode u_dec (
    .cur_st  (state_q),
    .run_req (interval_run_o),
    .chime   (chime_o)
  );

  // R11: the run request and the alarm never overlap
  p_out_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(interval_run_o && chime_o));

  // R5: an empty seat clears both outputs on the next edge
  p_empty_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !seat_occupied_i |=> (!interval_run_o && !chime_o));

  // R4: a latched belt on an occupied seat clears both outputs
  p_belt_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seat_occupied_i && belt_latched_i) |=> (!interval_run_o && !chime_o));

  // R3: the alarm rises only after an expiry seen while waiting
  p_chime_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chime_o) |-> ($past(interval_run_o) && $past(interval_done_i)));

  // R2: seated and unbelted outside the alarm starts the interval
  p_start_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!chime_o && !interval_run_o && seat_occupied_i && !belt_latched_i)
      |=> interval_run_o);

  // R10: the alarm holds while the condition persists
  p_chime_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (chime_o && seat_occupied_i && !belt_latched_i) |=> chime_o);
endmodule

// File: tb/belt_reminder_ctrl_tb_top.sv
module belt_reminder_ctrl_tb_top;
  logic clk;
  logic rst_n;
  logic seat_occupied_i;
  logic belt_latched_i;
  logic interval_done_i;
  logic interval_run_o;
  logic chime_o;

  int n_cmp;
  int n_bad;
  bit finished;

  belt_reminder_ctrl dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .seat_occupied_i (seat_occupied_i),
    .belt_latched_i  (belt_latched_i),
    .interval_done_i (interval_done_i),
    .interval_run_o  (interval_run_o),
    .chime_o         (chime_o)
  );

  // 250 MHz clock
  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic run_got, input logic run_exp,
                       input logic chm_got, input logic chm_exp);
    n_cmp++;
    if (run_got !== run_exp || chm_got !== chm_exp) begin
      n_bad++;
      $display("FAIL %s: run=%b chime=%b expected run=%b chime=%b",
               req, run_got, chm_got, run_exp, chm_exp);
    end
  endtask

  // Inputs are driven at the falling edge; the outputs are sampled 1 ns after the next rising edge.
  task automatic drive_step(input logic s, input logic b, input logic d);
    @(negedge clk);
    seat_occupied_i = s;
    belt_latched_i  = b;
    interval_done_i = d;
    @(posedge clk);
    #1;
  endtask

  task automatic go_empty();
    drive_step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    check("R1 in reset", interval_run_o, 1'b0, chime_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 after release", interval_run_o, 1'b0, chime_o, 1'b0);
  endtask

  task automatic t_sit_and_alarm();
    go_empty();
    drive_step(1'b1, 1'b0, 1'b0);
    check("R2 sit unbelted", interval_run_o, 1'b1, chime_o, 1'b0);
    drive_step(1'b1, 1'b0, 1'b0);
    check("R2 still waiting", interval_run_o, 1'b1, chime_o, 1'b0);
    drive_step(1'b1, 1'b0, 1'b1);
    check("R3 expiry", interval_run_o, 1'b0, chime_o, 1'b1);
    drive_step(1'b1, 1'b0, 1'b0);
    check("R10 alarm holds", interval_run_o, 1'b0, chime_o, 1'b1);
    drive_step(1'b1, 1'b1, 1'b0);
    check("R4 belt clears alarm", interval_run_o, 1'b0, chime_o, 1'b0);
  endtask

  task automatic t_leave_seat();
    go_empty();
    drive_step(1'b1, 1'b0, 1'b0);
    drive_step(1'b1, 1'b0, 1'b1);
    check("R3 alarm before leave", interval_run_o, 1'b0, chime_o, 1'b1);
    drive_step(1'b0, 1'b0, 1'b1);
    check("R5 leave from alarm", interval_run_o, 1'b0, chime_o, 1'b0);
    drive_step(1'b1, 1'b0, 1'b0);
    drive_step(1'b0, 1'b1, 1'b0);
    check("R5 leave from wait", interval_run_o, 1'b0, chime_o, 1'b0);
  endtask

  task automatic t_unbelt_restart();
    go_empty();
    drive_step(1'b1, 1'b0, 1'b0);
    drive_step(1'b1, 1'b1, 1'b0);
    check("R4 belt in wait", interval_run_o, 1'b0, chime_o, 1'b0);
    drive_step(1'b1, 1'b0, 1'b0);
    check("R6 unbelt restarts", interval_run_o, 1'b1, chime_o, 1'b0);
  endtask

  task automatic t_done_ignored();
    go_empty();
    drive_step(1'b0, 1'b0, 1'b1);
    check("R7 expiry on empty seat", interval_run_o, 1'b0, chime_o, 1'b0);
    drive_step(1'b1, 1'b1, 1'b1);
    check("R8 sit belted", interval_run_o, 1'b0, chime_o, 1'b0);
    drive_step(1'b1, 1'b1, 1'b1);
    check("R7 expiry when secured", interval_run_o, 1'b0, chime_o, 1'b0);
  endtask

  task automatic t_belt_vs_done();
    go_empty();
    drive_step(1'b1, 1'b0, 1'b0);
    drive_step(1'b1, 1'b1, 1'b1);
    check("R9 belt beats expiry", interval_run_o, 1'b0, chime_o, 1'b0);
  endtask

  task automatic t_async_reset();
    go_empty();
    drive_step(1'b1, 1'b0, 1'b0);
    drive_step(1'b1, 1'b0, 1'b1);
    check("R3 alarm before reset", interval_run_o, 1'b0, chime_o, 1'b1);
    #0.5;
    rst_n = 1'b0;
    #0.5;
    check("R1 async clear", interval_run_o, 1'b0, chime_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    n_cmp = 0;
    n_bad = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    seat_occupied_i = 1'b0;
    belt_latched_i  = 1'b0;
    interval_done_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_sit_and_alarm();
    t_leave_seat();
    t_unbelt_restart();
    t_done_ignored();
    t_belt_vs_done();
    t_async_reset();
    go_empty();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run=%b chime=%b expected completion", interval_run_o, chime_o);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule